// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a slave-only two-wire serial target. It gives a bus master access to a small bank of 8-bit control registers. Every transfer is a block transfer. The master first sends a starting register index. A write then carries a byte count and that many data bytes. A read turns the bus around with a repeated START, and the target then returns a byte count followed by register bytes. The register index advances by one after each data byte in both directions.

Both bus lines are sampled with the system clock. Each line passes through a two-stage synchronizer and a stability filter before START, STOP and clock edges are decoded. SDA is open-drain. The block only ever pulls the line low through an output enable, and its data output is tied low.

The register contents leave the block as parallel registered outputs, so that a neighbouring output-control block can use them directly:
- Index 0 holds the mode byte.
- Index 1 holds eight per-output enable bits.
- Index 2 holds eight per-output stop-select bits.
- Index 3 is a general-purpose byte.
- Index 4 is a read-only identification byte.

Top module: `smb_blkreg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 1101110 (address byte 0xDC for a write, 0xDD for a read). It gives no ACK to any other address and leaves SDA released for the rest of that transfer.
- R2: A write transfer consists of address with write bit, start index, byte count N (1 or more) and N data bytes. The target ACKs every one of these bytes. Data byte k is stored at register index (start + k).
- R3: A byte count of 0 in a write is answered with NACK, and none of the data bytes that follow it are stored.
- R4: Data bytes beyond the announced count are answered with NACK and are not stored.
- R5: A read transfer runs as follows. The master sends address with write bit, the start index, a repeated START, and address with read bit. The target then returns the count byte 5, followed by the registers from the start index upward. After the master NACKs a byte, the target keeps SDA released.
- R6: After reset, the registers hold these values: index 0 = 0x07, index 1 = 0xFF, index 2 = 0x00, index 3 = 0x00.
- R7: Index 4 always reads 0x20. Writes to it are ACKed and have no effect.
- R8: In the mode byte (index 0), bits 3 to 5 always read 0 and ignore writes. Bits 0, 1, 2, 6 and 7 store the written value.
- R9: Indices 5 to 255 read as 0x00 and ignore writes. Data bytes sent to them are still ACKed.
- R10: A change on SCL or SDA takes effect only after the synchronized line has held the new level for at least 3 system clocks. A pulse of 2 clocks does not disturb a transfer.
- R11: A START or STOP received in the middle of a byte aborts the transfer. A partly received byte is not stored, and SDA is released on the cycle after a STOP.
- R12: The SDA data output is always 0. The output enable changes only in the cycle after a filtered SCL falling edge, a START or a STOP.
- R13: The per-output enable outputs change only in the cycle after a write to index 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_o | output | 1 | Data value driven when enabled (always 0) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| ctrl_cfg | output | 8 | Mode register, index 0 |
| out_en | output | 8 | Per-output enable register, index 1 |
| stop_sel | output | 8 | Per-output stop-select register, index 2 |
| aux_cfg | output | 8 | General-purpose register, index 3 |

## Verification
Four properties are checked on every cycle:
- Filtered line changes always follow three equal synchronized samples.
- SDA is released after a STOP.
- The SDA enable moves only after a filtered SCL fall or a bus condition.
- The enable register changes only after a write aimed at index 1.

Other behaviour can only be shown by the bench's bit-level transfers. This covers address matching, byte-count semantics including zero and overrun, register masking and read-back, glitch rejection on a live transfer, and abort by STOP in mid-byte. Mixed random write and read blocks are compared against a register model kept in the bench.

// File: rtl/smb_blkreg_pkg.sv
package smb_blkreg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_RW = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } link_state_t;

  typedef enum logic [2:0] {
    PH_ADDR, PH_OFFS, PH_CNT, PH_WDATA, PH_RCNT, PH_RDATA
  } xfer_phase_t;

  function automatic logic [BYTE_W-1:0] reg_reset(input int unsigned idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] reg_wmask(input int unsigned idx);
    case (idx)
      0:       return 8'hC7;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned STABLE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic synced,
  output logic filt
);
  localparam int unsigned CW = $clog2(STABLE_CYC + 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;

  assign synced = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      cnt_q  <= '0;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      prev_q <= synced;
      if (synced != prev_q) begin
        cnt_q <= '0;
      end else if (cnt_q != CW'(STABLE_CYC - 1)) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (synced == prev_q && cnt_q == CW'(STABLE_CYC - 1)) begin
        filt <= synced;
      end
    end
  end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_blkreg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [BYTE_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [BYTE_W-1:0]             rd_idx,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [NUM_RW-1:0][BYTE_W-1:0] regs_q
);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= reg_reset(g);
      end else if (wr_en && wr_idx == BYTE_W'(g)) begin
        regs_q[g] <= wr_data & reg_wmask(g);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == BYTE_W'(NUM_RW)) rd_data = ID_VALUE;
    for (int i = 0; i < NUM_RW; i++) begin
      if (rd_idx == BYTE_W'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_blkreg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR   = 7'b1101110,
  parameter logic [BYTE_W-1:0] READ_COUNT = 8'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              sda_drive,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              ev_fall
);
  logic              scl_d, sda_d, ev_rise;
  link_state_t       st_q;
  xfer_phase_t       ph_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] sh_q, ptr_q, left_q;

  assign ev_start = scl_f & scl_d & sda_d & ~sda_f;
  assign ev_stop  = scl_f & scl_d & ~sda_d & sda_f;
  assign ev_rise  = scl_f & ~scl_d;
  assign ev_fall  = ~scl_f & scl_d;
  assign rd_idx   = (ph_q == PH_RDATA) ? ptr_q + 8'd1 : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      st_q      <= ST_IDLE;
      ph_q      <= PH_ADDR;
      bit_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      left_q    <= '0;
      sda_drive <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_en <= 1'b0;
      if (ev_stop) begin
        st_q      <= ST_IDLE;
        sda_drive <= 1'b0;
      end else if (ev_start) begin
        st_q      <= ST_RX;
        ph_q      <= PH_ADDR;
        bit_q     <= '0;
        sda_drive <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              bit_q <= bit_q + 4'd1;
            end else if (ev_fall && bit_q == 4'd8) begin
              bit_q <= '0;
              st_q  <= ST_WAIT;
              case (ph_q)
                PH_ADDR: if (sh_q[7:1] == DEV_ADDR) begin
                  sda_drive <= 1'b1;
                  st_q      <= ST_RX_ACK;
                  ph_q      <= sh_q[0] ? PH_RCNT : PH_OFFS;
                end
                PH_OFFS: begin
                  ptr_q     <= sh_q;
                  sda_drive <= 1'b1;
                  st_q      <= ST_RX_ACK;
                  ph_q      <= PH_CNT;
                end
                PH_CNT: if (sh_q != '0) begin
                  left_q    <= sh_q;
                  sda_drive <= 1'b1;
                  st_q      <= ST_RX_ACK;
                  ph_q      <= PH_WDATA;
                end
                PH_WDATA: if (left_q != '0) begin
                  wr_en     <= 1'b1;
                  wr_idx    <= ptr_q;
                  wr_data   <= sh_q;
                  ptr_q     <= ptr_q + 8'd1;
                  left_q    <= left_q - 8'd1;
                  sda_drive <= 1'b1;
                  st_q      <= ST_RX_ACK;
                end
                default: ;
              endcase
            end
          end
          ST_RX_ACK: if (ev_fall) begin
            if (ph_q == PH_RCNT) begin
              st_q      <= ST_TX;
              sh_q      <= READ_COUNT;
              sda_drive <= ~READ_COUNT[7];
              bit_q     <= 4'd1;
            end else begin
              st_q      <= ST_RX;
              sda_drive <= 1'b0;
            end
          end
          ST_TX: if (ev_fall) begin
            if (bit_q == 4'd8) begin
              sda_drive <= 1'b0;
              st_q      <= ST_TX_ACK;
            end else begin
              sda_drive <= ~sh_q[6];
              sh_q      <= {sh_q[6:0], 1'b0};
              bit_q     <= bit_q + 4'd1;
            end
          end
          ST_TX_ACK: begin
            if (ev_rise && sda_f) begin
              st_q <= ST_WAIT;
            end else if (ev_fall) begin
              if (ph_q == PH_RDATA) ptr_q <= ptr_q + 8'd1;
              ph_q      <= PH_RDATA;
              sh_q      <= rd_data;
              sda_drive <= ~rd_data[7];
              bit_q     <= 4'd1;
              st_q      <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target
  import smb_blkreg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'b1101110,
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h20,
  parameter int unsigned       FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ctrl_cfg,
  output logic [BYTE_W-1:0] out_en,
  output logic [BYTE_W-1:0] stop_sel,
  output logic [BYTE_W-1:0] aux_cfg
);
  localparam logic [BYTE_W-1:0] READ_COUNT = BYTE_W'(NUM_RW + 1);

  logic scl_s, scl_f, sda_s, sda_f;
  logic ev_start, ev_stop, ev_fall, wr_en;
  logic [BYTE_W-1:0] wr_idx, wr_data, rd_idx, rd_data;
  logic [NUM_RW-1:0][BYTE_W-1:0] regs_q;

  smb_line_filter #(.STABLE_CYC(FILT_LEN)) i_scl_filt (
    .clk(clk), .rst(rst), .raw(scl_i), .synced(scl_s), .filt(scl_f));
  smb_line_filter #(.STABLE_CYC(FILT_LEN)) i_sda_filt (
    .clk(clk), .rst(rst), .raw(sda_i), .synced(sda_s), .filt(sda_f));

  smb_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .READ_COUNT(READ_COUNT)) i_fsm (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .rd_data(rd_data), .rd_idx(rd_idx), .sda_drive(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_fall(ev_fall));

  smb_reg_bank #(.ID_VALUE(ID_VALUE)) i_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_q(regs_q));

  assign sda_o    = 1'b0;
  assign ctrl_cfg = regs_q[0];
  assign out_en   = regs_q[1];
  assign stop_sel = regs_q[2];
  assign aux_cfg  = regs_q[3];
endmodule

// File: rtl/smb_blkreg_chk.sv
module smb_blkreg_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       scl_f,
  input logic       sda_s,
  input logic       sda_f,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_fall,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [7:0] wr_idx,
  input logic [7:0] out_en
);
  assert_scl_filter_R10: assert property (@(posedge clk) disable iff (rst)
    (scl_f != $past(scl_f)) |->
      ($past(scl_s, 1) == $past(scl_s, 2)) && ($past(scl_s, 2) == $past(scl_s, 3))
      && (scl_f == $past(scl_s, 1)));

  assert_sda_filter_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_f != $past(sda_f)) |->
      ($past(sda_s, 1) == $past(sda_s, 2)) && ($past(sda_s, 2) == $past(sda_s, 3))
      && (sda_f == $past(sda_s, 1)));

  assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !sda_oe);

  assert_drive_after_fall_R12: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(ev_fall) || $past(ev_start) || $past(ev_stop)));

  assert_enable_by_write_R13: assert property (@(posedge clk) disable iff (rst)
    (out_en != $past(out_en)) |-> ($past(wr_en) && $past(wr_idx) == 8'd1));
endmodule

bind smb_blkreg_target smb_blkreg_chk i_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .scl_f(scl_f), .sda_s(sda_s), .sda_f(sda_f),
  .ev_start(ev_start), .ev_stop(ev_stop), .ev_fall(ev_fall), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_idx(wr_idx), .out_en(out_en));

// File: tb/test_smb_blkreg_target.sv
module test_smb_blkreg_target;
  localparam int QP = 8;
  localparam int HP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic glitch = 1'b0;
  logic sda_line;
  logic sda_o, sda_oe;
  logic [7:0] ctrl_cfg, out_en, stop_sel, aux_cfg;
  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [5];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #4 clk = ~clk;
  assign sda_line = (m_sda & ~(sda_oe & ~sda_o)) ^ glitch;

  smb_blkreg_target i_smb_blkreg_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_o(sda_o),
    .sda_oe(sda_oe), .ctrl_cfg(ctrl_cfg), .out_en(out_en), .stop_sel(stop_sel),
    .aux_cfg(aux_cfg));

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mdl_rd(input int idx);
    if (idx < 4) return mdl[idx];
    if (idx == 4) return 8'h20;
    return 8'h00;
  endfunction

  function automatic logic [7:0] mask_of(input int idx);
    return (idx == 0) ? 8'hC7 : 8'hFF;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(QP); m_sda = 1'b1; tick(QP); m_scl = 1'b1; tick(QP); m_sda = 1'b0; tick(QP); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(QP); m_sda = 1'b0; tick(QP); m_scl = 1'b1; tick(QP); m_sda = 1'b1; tick(HP);
  endtask

  task automatic send_bit(input logic b, input logic glt);
    tick(QP); m_sda = b; tick(QP); m_scl = 1'b1;
    if (glt) begin
      tick(4); glitch = 1'b1; tick(2); glitch = 1'b0; tick(HP - 6);
    end else begin
      tick(HP);
    end
    m_scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    tick(QP); m_sda = 1'b1; tick(QP); m_scl = 1'b1; tick(QP); b = sda_line; tick(QP); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic glt, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glt && i == 3);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(nack, 1'b0);
  endtask

  task automatic wr_block(input logic [7:0] off, input logic [7:0] cnt, input int nb,
                          output logic hdr_ok, output logic cnt_ack, output logic [7:0] dack);
    logic a0, a1;
    bus_start();
    send_byte(8'hDC, 1'b0, a0);
    send_byte(off, 1'b0, a1);
    send_byte(cnt, 1'b0, cnt_ack);
    hdr_ok = a0 & a1;
    dack = '0;
    for (int i = 0; i < nb; i++) send_byte(wbuf[i], 1'b0, dack[i]);
    bus_stop();
  endtask

  task automatic rd_block(input logic [7:0] off, input int nb, output logic hdr_ok, output logic [7:0] cnt);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hDC, 1'b0, a0);
    send_byte(off, 1'b0, a1);
    bus_start();
    send_byte(8'hDD, 1'b0, a2);
    hdr_ok = a0 & a1 & a2;
    recv_byte(1'b0, cnt);
    for (int i = 0; i < nb; i++) recv_byte(i == nb - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic mdl_write(input int off, input int n);
    for (int i = 0; i < n; i++) if (off + i < 4) mdl[off + i] = wbuf[i] & mask_of(off + i);
  endtask

  task automatic check_ports(input string tag);
    chk(ctrl_cfg == mdl[0], tag, ctrl_cfg, mdl[0]);
    chk(out_en == mdl[1], tag, out_en, mdl[1]);
    chk(stop_sel == mdl[2], tag, stop_sel, mdl[2]);
    chk(aux_cfg == mdl[3], tag, aux_cfg, mdl[3]);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic hok, cack, ack;
    logic [7:0] dack, cnt;
    void'($urandom(32'd20250611));
    mdl[0] = 8'h07; mdl[1] = 8'hFF; mdl[2] = 8'h00; mdl[3] = 8'h00;
    tick(5); rst = 1'b0; tick(5);

    // R6 reset state, R12 released line
    check_ports("R6 reset value");
    chk(!sda_oe && !sda_o, "R12 idle release", {7'd0, sda_oe}, 8'h00);

    // R5, R7, R9: read from the ID index and beyond
    rd_block(8'd4, 2, hok, cnt);
    chk(hok, "R5 read header ack", {7'd0, hok}, 8'h01);
    chk(cnt == 8'd5, "R5 count byte", cnt, 8'd5);
    chk(rbuf[0] == 8'h20, "R7 id value", rbuf[0], 8'h20);
    chk(rbuf[1] == 8'h00, "R9 unimplemented read", rbuf[1], 8'h00);
    chk(!sda_oe, "R5 released after NACK", {7'd0, sda_oe}, 8'h00);

    // R1 wrong address
    bus_start(); send_byte(8'hDE, 1'b0, ack);
    chk(!ack, "R1 foreign address not acked", {7'd0, ack}, 8'h00);
    send_byte(8'h00, 1'b0, ack);
    chk(!ack && !sda_oe, "R1 stays released", {7'd0, ack}, 8'h00);
    bus_stop();

    // R2, R4, R8: count 2 with a third byte
    wbuf[0] = 8'hFF; wbuf[1] = 8'h12; wbuf[2] = 8'h99;
    wr_block(8'd0, 8'd2, 3, hok, cack, dack);
    chk(hok && cack, "R2 header acks", {6'd0, hok, cack}, 8'h03);
    chk(dack[1:0] == 2'b11, "R2 data acks", dack, 8'h03);
    chk(!dack[2], "R4 overrun byte NACK", dack, 8'h03);
    mdl_write(0, 2);
    chk(ctrl_cfg == 8'hC7, "R8 reserved bits masked", ctrl_cfg, 8'hC7);
    check_ports("R4 overrun not stored");

    // R3 zero count, R13 enable untouched
    wbuf[0] = 8'h55;
    wr_block(8'd2, 8'd0, 1, hok, cack, dack);
    chk(!cack, "R3 zero count NACK", {7'd0, cack}, 8'h00);
    chk(!dack[0], "R3 data after zero count NACK", dack, 8'h00);
    chk(out_en == 8'h12, "R13 enable unchanged", out_en, 8'h12);
    check_ports("R3 nothing stored");

    // R7, R9 writes across the ID and unimplemented indices
    wbuf[0] = 8'hAA; wbuf[1] = 8'hFF; wbuf[2] = 8'h77;
    wr_block(8'd3, 8'd3, 3, hok, cack, dack);
    chk(dack[2:0] == 3'b111, "R9 out-of-range bytes acked", dack, 8'h07);
    mdl_write(3, 3);
    check_ports("R2 write index 3");
    rd_block(8'd3, 3, hok, cnt);
    chk(rbuf[0] == 8'hAA, "R2 readback index 3", rbuf[0], 8'hAA);
    chk(rbuf[1] == 8'h20, "R7 id ignores write", rbuf[1], 8'h20);
    chk(rbuf[2] == 8'h00, "R9 index 5 ignores write", rbuf[2], 8'h00);

    // R10 glitch of 2 clocks during a data bit
    bus_start(); send_byte(8'hDC, 1'b0, ack); send_byte(8'd2, 1'b0, ack);
    send_byte(8'd1, 1'b0, ack); send_byte(8'h81, 1'b1, ack);
    chk(ack, "R10 glitch ignored ack", {7'd0, ack}, 8'h01);
    bus_stop();
    mdl[2] = 8'h81;
    chk(stop_sel == 8'h81, "R10 glitch ignored data", stop_sel, 8'h81);

    // R11 abort by STOP in mid byte
    bus_start(); send_byte(8'hDC, 1'b0, ack); send_byte(8'd3, 1'b0, ack);
    send_byte(8'd1, 1'b0, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    bus_stop();
    chk(aux_cfg == 8'hAA, "R11 partial byte dropped", aux_cfg, 8'hAA);
    chk(!sda_oe, "R11 released after stop", {7'd0, sda_oe}, 8'h00);

    // random write/read mix against the model
    for (int it = 0; it < 12; it++) begin
      int off, n;
      off = $urandom_range(0, 6);
      n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_block(8'(off), 8'(n), n, hok, cack, dack);
      chk(hok && cack && dack == 8'((1 << n) - 1), "R2 random acks", dack, 8'((1 << n) - 1));
      mdl_write(off, n);
      check_ports("R2 random ports");
      off = $urandom_range(0, 5);
      n = $urandom_range(1, 4);
      rd_block(8'(off), n, hok, cnt);
      chk(hok && cnt == 8'd5, "R5 random count", cnt, 8'd5);
      for (int i = 0; i < n; i++)
        chk(rbuf[i] == mdl_rd(off + i), "R5 random readback", rbuf[i], mdl_rd(off + i));
    end
    chk(sda_o == 1'b0, "R12 data output low", {7'd0, sda_o}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule